// File: doc/BRIEF.md
# Character LCD 4-bit Bus Controller

This block drives a character display controller over a four-line data bus with three control lines: register select, read/write and a strobe. A host hands over one byte at a time, together with a flag that selects instruction or data. The block sends the byte as two nibbles, high nibble first. It then reads the busy flag back over the same bus, one nibble pair per poll, until the display reports idle. The host sees only a valid/ready pair, so it never waits out fixed instruction delays.

After reset the block runs the display's power-up sequence without host help. It first waits, then sends four single-nibble writes while the display may still be in eight-bit mode. It then sends the full-byte setup instructions, and the busy flag is polled after each of them. The display pulls its data lines up weakly. A missing or stuck display therefore reads as permanently busy. A poll limit catches this case: the block falls back to a fixed wait and raises an error flag.

A separate registered helper turns a (row, column) position on a four-row, twenty-column screen into the display RAM address. Rows 0 and 1 start at 0 and 64. Rows 2 and 3 continue those two lines, at 0 + COLS and 64 + COLS.

Top module: `lcd_nib_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, the strobe `lcd_e` is low, the bus is released (`lcd_d_oe`=0), and `req_ready` and `init_done` are low.
- R2: After reset the block waits INIT_WAIT_CYC cycles. It then makes four single-nibble writes of 0x3, 0x3, 0x3, 0x2, with RS=0 and R/W=0, and waits INIT_WAIT_CYC cycles after each one. No bus read happens during this phase.
- R3: The block then sends the bytes 0x28, 0x08, 0x01, 0x06 and 0x0C in that order, with RS=0, each followed by busy polling. It then raises `init_done` and `req_ready`.
- R4: An accepted byte goes out as two writes, bits 7:4 first and then bits 3:0, with RS equal to `req_rs` and R/W=0.
- R5: Before each strobe pulse, RS and R/W are stable for at least SETUP_CYC cycles. `lcd_e` stays high for exactly E_CYC cycles. RS, R/W and the write data stay unchanged in the cycle after `lcd_e` falls.
- R6: After each full byte the block polls with reads (RS=0, R/W=1), two strobes per poll. Bus bit 3 of the first nibble is the busy flag (byte bit 7). Bits 2:0 of the first nibble and all four bits of the second form the 7-bit address. Polling repeats while the flag is 1. On a clear flag, `disp_addr` takes the address that was read.
- R7: The bus is released during reads. `lcd_d_oe` is high only in a cycle where R/W is low and was also low in the previous cycle.
- R8: If the flag is still 1 after POLL_MAX polls, polling stops. The block waits FALLBACK_CYC cycles and sets `busy_err`. `busy_err` clears when the next request is accepted.
- R9: A request is taken only when `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low produces no bus write.
- R10: One cycle after `map_row`/`map_col` are applied, `map_addr` holds the row base plus the column. The row bases are: row 0 = 0, row 1 = 64, row 2 = 20, row 3 = 84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a byte |
| req_rs | input | 1 | 1 = data byte, 0 = instruction byte |
| req_byte | input | 8 | Byte to send |
| req_ready | output | 1 | Block idle and initialised, request will be taken |
| init_done | output | 1 | Power-up sequence complete |
| busy_err | output | 1 | Last busy wait ended by poll timeout |
| disp_addr | output | 7 | Address counter from the last clear poll |
| lcd_rs | output | 1 | Register select line |
| lcd_rw | output | 1 | Read/write line, 1 = read |
| lcd_e | output | 1 | Strobe, rests low |
| lcd_d_out | output | 4 | Nibble driven onto the bus |
| lcd_d_oe | output | 1 | Bus drive enable |
| lcd_d_in | input | 4 | Nibble read from the bus (pull-ups give 1s) |
| map_row | input | 2 | Row for the position helper |
| map_col | input | COL_W | Column for the position helper |
| map_addr | output | 7 | Display RAM address of the position |

## Verification
The hardest behaviour to reach from the ports is the exact edge of the poll limit. A byte whose busy flag clears on the last allowed poll must finish cleanly. One that is still busy on that poll must fall into the timed fallback. The bench's display model keeps the busy flag set for a programmable number of polls after each byte, so the limit is hit from both sides. A switch to an absent display, in which the bus reads all ones through the pull-ups, then drives the timeout path. The next request shows that the error clears.

// File: rtl/lcd_nib_pkg.sv
`timescale 1ns/1ps
package lcd_nib_pkg;

  localparam int INIT_NIBS  = 4;
  localparam int INIT_BYTES = 5;

  typedef enum logic [3:0] {
    C_PWR, C_INIB, C_LOAD, C_HI, C_LO, C_PH, C_PL, C_FB, C_END, C_IDLE
  } ctrl_st_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD
  } phy_st_t;

  // single-nibble steps while the display may still be in 8-bit mode
  function automatic logic [3:0] init_nib(input logic [2:0] idx);
    return (idx < 3'd3) ? 4'h3 : 4'h2;
  endfunction

  // full-byte setup: 4-bit two-line, display off, clear, increment, display on
  function automatic logic [7:0] init_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h28;
      3'd1:    return 8'h08;
      3'd2:    return 8'h01;
      3'd3:    return 8'h06;
      default: return 8'h0C;
    endcase
  endfunction

endpackage

// File: rtl/lcd_nib_phy.sv
`timescale 1ns/1ps
module lcd_nib_phy
  import lcd_nib_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int E_CYC     = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       go_rs,
  input  logic       go_rw,
  input  logic [3:0] go_nib,
  output logic       done,
  output logic [3:0] rd_nib,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_d_out,
  output logic       lcd_d_oe,
  input  logic [3:0] lcd_d_in
);

  localparam int MAXC = (SETUP_CYC > E_CYC) ? SETUP_CYC : E_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] E_LD   = CW'(E_CYC - 1);

  phy_st_t       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      rd_nib    <= 4'h0;
      lcd_rs    <= 1'b0;
      lcd_rw    <= 1'b0;
      lcd_e     <= 1'b0;
      lcd_d_out <= 4'h0;
      lcd_d_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        PH_IDLE: begin
          if (go) begin
            lcd_rs    <= go_rs;
            lcd_rw    <= go_rw;
            lcd_d_oe  <= !go_rw;
            lcd_d_out <= go_rw ? 4'h0 : go_nib;
            cnt       <= SET_LD;
            st        <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            lcd_e <= 1'b1;
            cnt   <= E_LD;
            st    <= PH_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            lcd_e  <= 1'b0;
            rd_nib <= lcd_d_in;
            st     <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          // park: R/W back low and bus released before the next transfer
          lcd_rw   <= 1'b0;
          lcd_d_oe <= 1'b0;
          done     <= 1'b1;
          st       <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_pos_map.sv
`timescale 1ns/1ps
module lcd_pos_map #(
  parameter  int COLS  = 20,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       row,
  input  logic [COL_W-1:0] col,
  output logic [6:0]       addr
);

  localparam logic [6:0] LINE2_BASE = 7'd64;
  localparam logic [6:0] HALF_OFS   = 7'(COLS);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= 7'd0;
    end else begin
      addr <= (row[0] ? LINE2_BASE : 7'd0) + (row[1] ? HALF_OFS : 7'd0) + 7'(col);
    end
  end

endmodule

// File: rtl/lcd_nib_ctrl.sv
`timescale 1ns/1ps
module lcd_nib_ctrl
  import lcd_nib_pkg::*;
#(
  parameter  int SETUP_CYC     = 4,
  parameter  int E_CYC         = 50,
  parameter  int INIT_WAIT_CYC = 1600000,
  parameter  int FALLBACK_CYC  = 200000,
  parameter  int POLL_MAX      = 4096,
  parameter  int COLS          = 20,
  localparam int COL_W         = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_rs,
  input  logic [7:0]       req_byte,
  output logic             req_ready,
  output logic             init_done,
  output logic             busy_err,
  output logic [6:0]       disp_addr,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e,
  output logic [3:0]       lcd_d_out,
  output logic             lcd_d_oe,
  input  logic [3:0]       lcd_d_in,
  input  logic [1:0]       map_row,
  input  logic [COL_W-1:0] map_col,
  output logic [6:0]       map_addr
);

  localparam int WAIT_MAX = (INIT_WAIT_CYC > FALLBACK_CYC) ? INIT_WAIT_CYC : FALLBACK_CYC;
  localparam int WW       = $clog2(WAIT_MAX + 1);
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam logic [WW-1:0] INIT_LD   = WW'(INIT_WAIT_CYC - 1);
  localparam logic [WW-1:0] FB_LD     = WW'(FALLBACK_CYC - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
  localparam logic [2:0]    NIB_CNT   = 3'(INIT_NIBS);
  localparam logic [2:0]    BYTE_LAST = 3'(INIT_BYTES - 1);

  ctrl_st_t      st;
  logic [WW-1:0] wcnt;
  logic [PW-1:0] polls;
  logic [2:0]    nstep;
  logic [2:0]    bstep;
  logic [7:0]    cur_byte;
  logic          cur_rs;
  logic          bf;
  logic [2:0]    addr_hi;
  logic          go, go_rs, go_rw;
  logic [3:0]    go_nib;
  logic          phy_done;
  logic [3:0]    rd_nib;

  lcd_nib_phy #(
    .SETUP_CYC (SETUP_CYC),
    .E_CYC     (E_CYC)
  ) u_phy (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_rs     (go_rs),
    .go_rw     (go_rw),
    .go_nib    (go_nib),
    .done      (phy_done),
    .rd_nib    (rd_nib),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_e     (lcd_e),
    .lcd_d_out (lcd_d_out),
    .lcd_d_oe  (lcd_d_oe),
    .lcd_d_in  (lcd_d_in)
  );

  lcd_pos_map #(
    .COLS (COLS)
  ) u_map (
    .clk  (clk),
    .rst  (rst),
    .row  (map_row),
    .col  (map_col),
    .addr (map_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_PWR;
      wcnt      <= INIT_LD;
      polls     <= '0;
      nstep     <= 3'd0;
      bstep     <= 3'd0;
      cur_byte  <= 8'h00;
      cur_rs    <= 1'b0;
      bf        <= 1'b0;
      addr_hi   <= 3'd0;
      go        <= 1'b0;
      go_rs     <= 1'b0;
      go_rw     <= 1'b0;
      go_nib    <= 4'h0;
      req_ready <= 1'b0;
      init_done <= 1'b0;
      busy_err  <= 1'b0;
      disp_addr <= 7'd0;
    end else begin
      go <= 1'b0;
      case (st)
        C_PWR: begin
          if (wcnt == '0) begin
            if (nstep < NIB_CNT) begin
              go     <= 1'b1;
              go_rs  <= 1'b0;
              go_rw  <= 1'b0;
              go_nib <= init_nib(nstep);
              st     <= C_INIB;
            end else begin
              cur_byte <= init_byte(bstep);
              cur_rs   <= 1'b0;
              st       <= C_LOAD;
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        C_INIB: begin
          if (phy_done) begin
            nstep <= nstep + 3'd1;
            wcnt  <= INIT_LD;
            st    <= C_PWR;
          end
        end
        C_LOAD: begin
          go     <= 1'b1;
          go_rs  <= cur_rs;
          go_rw  <= 1'b0;
          go_nib <= cur_byte[7:4];
          st     <= C_HI;
        end
        C_HI: begin
          if (phy_done) begin
            go     <= 1'b1;
            go_nib <= cur_byte[3:0];
            st     <= C_LO;
          end
        end
        C_LO: begin
          if (phy_done) begin
            go     <= 1'b1;
            go_rs  <= 1'b0;
            go_rw  <= 1'b1;
            go_nib <= 4'h0;
            polls  <= '0;
            st     <= C_PH;
          end
        end
        C_PH: begin
          if (phy_done) begin
            bf      <= rd_nib[3];
            addr_hi <= rd_nib[2:0];
            go      <= 1'b1;
            st      <= C_PL;
          end
        end
        C_PL: begin
          if (phy_done) begin
            if (!bf) begin
              disp_addr <= {addr_hi, rd_nib};
              st        <= C_END;
            end else if (polls == POLL_LAST) begin
              busy_err <= 1'b1;
              wcnt     <= FB_LD;
              st       <= C_FB;
            end else begin
              polls <= polls + 1'b1;
              go    <= 1'b1;
              st    <= C_PH;
            end
          end
        end
        C_FB: begin
          if (wcnt == '0) st <= C_END;
          else            wcnt <= wcnt - 1'b1;
        end
        C_END: begin
          go_rw <= 1'b0;
          if (!init_done) begin
            if (bstep == BYTE_LAST) begin
              init_done <= 1'b1;
              req_ready <= 1'b1;
              st        <= C_IDLE;
            end else begin
              bstep    <= bstep + 3'd1;
              cur_byte <= init_byte(bstep + 3'd1);
              cur_rs   <= 1'b0;
              st       <= C_LOAD;
            end
          end else begin
            req_ready <= 1'b1;
            st        <= C_IDLE;
          end
        end
        C_IDLE: begin
          if (req_valid && req_ready) begin
            cur_byte  <= req_byte;
            cur_rs    <= req_rs;
            busy_err  <= 1'b0;
            req_ready <= 1'b0;
            st        <= C_LOAD;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_nib_ctrl_chk.sv
`timescale 1ns/1ps
module lcd_nib_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [3:0] lcd_d_out,
  input logic       lcd_d_oe,
  input logic       req_valid,
  input logic       req_ready,
  input logic       init_done,
  input logic       busy_err
);

  // R1
  a_r1_rest_after_reset: assert property (@(posedge clk)
    rst |=> (!lcd_e && !lcd_d_oe && !req_ready && !init_done));

  // R5
  a_r5_ctrl_stable_strobe: assert property (@(posedge clk) disable iff (rst)
    lcd_e |-> ($stable(lcd_rs) && $stable(lcd_rw)));

  a_r5_data_stable_strobe: assert property (@(posedge clk) disable iff (rst)
    (lcd_e && lcd_d_oe) |-> ($stable(lcd_d_out) && $stable(lcd_d_oe)));

  a_r5_hold_after_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)));

  // R7
  a_r7_drive_after_rw_low: assert property (@(posedge clk) disable iff (rst)
    lcd_d_oe |-> (!lcd_rw && !$past(lcd_rw)));

  // R9
  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (init_done && !lcd_e));

  // R8
  a_r8_err_clears_on_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !busy_err);

endmodule

bind lcd_nib_ctrl lcd_nib_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .lcd_rs    (lcd_rs),
  .lcd_rw    (lcd_rw),
  .lcd_e     (lcd_e),
  .lcd_d_out (lcd_d_out),
  .lcd_d_oe  (lcd_d_oe),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .init_done (init_done),
  .busy_err  (busy_err)
);

// File: tb/lcd_nib_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_nib_ctrl_bench;

  localparam int SETUP = 2;
  localparam int EW    = 3;
  localparam int IW    = 20;
  localparam int FB    = 30;
  localparam int PM    = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_rs;
  logic [7:0] req_byte;
  logic       req_ready, init_done, busy_err;
  logic [6:0] disp_addr;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_d_oe;
  logic [3:0] lcd_d_out, lcd_d_in;
  logic [1:0] map_row;
  logic [4:0] map_col;
  logic [6:0] map_addr;

  always #2.5 clk = ~clk;

  lcd_nib_ctrl #(
    .SETUP_CYC(SETUP), .E_CYC(EW), .INIT_WAIT_CYC(IW),
    .FALLBACK_CYC(FB), .POLL_MAX(PM), .COLS(20)
  ) u_lcd_nib_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rs(req_rs),
    .req_byte(req_byte), .req_ready(req_ready), .init_done(init_done),
    .busy_err(busy_err), .disp_addr(disp_addr), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in), .map_row(map_row),
    .map_col(map_col), .map_addr(map_addr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // display model
  bit         absent = 0;
  int         busy_cfg = 0;
  int         busy_left = 0;
  bit         rd_phase = 0;
  int         wr_cnt = 0;
  int         poll_pairs = 0;
  int         early_reads = 0;
  logic [6:0] addr_mdl = 7'd0;
  logic       bf_m;
  assign bf_m = (busy_left != 0);
  assign lcd_d_in = (absent || !lcd_e || !lcd_rw) ? 4'hF :
                    (!rd_phase ? {bf_m, addr_mdl[6:4]} : addr_mdl[3:0]);

  // scoreboard of expected bus writes {rs, nibble}
  logic [4:0] exp_q[$];
  logic [4:0] got_item;
  bit   prev_e = 0, prev_rs = 0, prev_rw = 0;
  int   e_len = 0, since_ctl = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (lcd_d_oe && (lcd_rw || prev_rw))
        check("R7 drive while R/W high", 1, 0);
      if (lcd_e && !prev_e)
        check("R5 setup before strobe", int'(since_ctl + 1 >= SETUP), 1);
      if (lcd_e) e_len++;
      if (!lcd_e && prev_e) begin
        check("R5 strobe width", e_len, EW);
        e_len = 0;
        if (lcd_rw) begin
          check("R7 bus released on read", int'(lcd_d_oe), 0);
          check("R6 poll uses RS=0", int'(lcd_rs), 0);
          if (wr_cnt < 5) early_reads++;
          if (rd_phase) begin
            if (busy_left > 0) busy_left--;
            poll_pairs++;
          end
          rd_phase = !rd_phase;
        end else begin
          if (exp_q.size() == 0) begin
            check("R9 unexpected bus write", int'({lcd_rs, lcd_d_out}), 'h1ff);
          end else begin
            got_item = exp_q.pop_front();
            check("R4 write nibble {rs,nib}", int'({lcd_rs, lcd_d_out}), int'(got_item));
          end
          wr_cnt++;
          if (wr_cnt > 4 && (wr_cnt % 2) == 0) begin
            busy_left = busy_cfg;
            addr_mdl = addr_mdl + 7'd1;
          end
        end
      end
      if (lcd_rs != prev_rs || lcd_rw != prev_rw) since_ctl = 0;
      else since_ctl++;
    end
    prev_e = lcd_e;
    prev_rs = lcd_rs;
    prev_rw = lcd_rw;
  end

  task automatic push_byte(input bit rs, input logic [7:0] b);
    exp_q.push_back({rs, b[7:4]});
    exp_q.push_back({rs, b[3:0]});
  endtask

  task automatic send(input bit rs, input logic [7:0] b);
    push_byte(rs, b);
    poll_pairs = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_rs = rs;
    req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_rs = 1'b0;
    req_byte = 8'h00;
    map_row = 2'd0;
    map_col = 5'd0;
    busy_cfg = 1;
    exp_q.push_back(5'h03);
    exp_q.push_back(5'h03);
    exp_q.push_back(5'h03);
    exp_q.push_back(5'h02);
    push_byte(0, 8'h28);
    push_byte(0, 8'h08);
    push_byte(0, 8'h01);
    push_byte(0, 8'h06);
    push_byte(0, 8'h0C);
    repeat (4) @(negedge clk);
    check("R1 strobe low in reset", int'(lcd_e), 0);
    check("R1 bus released in reset", int'(lcd_d_oe), 0);
    check("R1 ready low in reset", int'(req_ready), 0);
    check("R1 init_done low in reset", int'(init_done), 0);
    rst = 1'b0;
    // R9: request offered while not ready must be ignored
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    req_rs = 1'b1;
    req_byte = 8'hAA;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    check("R3 init_done after setup", int'(init_done), 1);
    check("R3 all setup writes seen", exp_q.size(), 0);
    check("R2 no reads in nibble phase", early_reads, 0);
    check("R6 init polls (2 per byte)", poll_pairs, 10);
    check("R9 ignored request not written", wr_cnt, 14);
    check("R6 address after init", int'(disp_addr), int'(addr_mdl));

    busy_cfg = 0;
    send(1, 8'hA5);
    check("R6 single poll when idle", poll_pairs, 1);
    check("R4 data byte consumed", exp_q.size(), 0);
    check("R6 address readback", int'(disp_addr), int'(addr_mdl));
    send(0, 8'h80);
    check("R4 instruction byte consumed", exp_q.size(), 0);

    busy_cfg = 2;
    send(1, 8'h41);
    check("R6 polls while busy", poll_pairs, 3);
    check("R8 no error below limit", int'(busy_err), 0);

    busy_cfg = 3;
    send(1, 8'h5A);
    check("R8 clear on last allowed poll", poll_pairs, 4);
    check("R8 no error at limit", int'(busy_err), 0);

    busy_cfg = 4;
    send(0, 8'h01);
    check("R8 polls stop at limit", poll_pairs, PM);
    check("R8 error after timeout", int'(busy_err), 1);

    busy_cfg = 0;
    absent = 1;
    send(1, 8'h7E);
    check("R8 absent display polls", poll_pairs, PM);
    check("R8 error with absent display", int'(busy_err), 1);

    absent = 0;
    send(1, 8'h33);
    check("R8 error cleared by next request", int'(busy_err), 0);
    check("R4 queue drained", exp_q.size(), 0);

    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) begin
        int c;
        int base;
        c = (k == 0) ? 0 : ((k == 1) ? 19 : 7);
        base = (r == 0) ? 0 : ((r == 1) ? 64 : ((r == 2) ? 20 : 84));
        @(negedge clk);
        map_row = 2'(r);
        map_col = 5'(c);
        @(negedge clk);
        check("R10 position map", int'(map_addr), base + c);
      end
    end

    repeat (5) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule